// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the serial clock of an I2C master in standard and fast operation. One clock-control count sets the period. A speed select and a ratio select then choose one of three high/low splits, and the count is raised to a mode-dependent floor. The block drives SCL through an open-drain style output, where a 1 means "pull the line low". It watches the actual line through a two-stage synchronizer, so a slave that holds SCL low stretches the low phase. It also emits a one-cycle strobe at the start of each low phase and each high phase, which a bit engine uses to change and sample data.

A combinational helper turns a peripheral-clock frequency code, in MHz, into the rise-time compensation value. The caller may feed that value back into the rise-time input. When the block is enabled, the high phase is shortened by the rise-time value, so that the slow edge of a pulled-up line counts as part of the high time. All timing inputs are captured only while the block is disabled. Enabling the block starts with SCL released.

Top module: `scl_timing_gen`

## Requirements
- R1: With `fast_sel`=0 (standard operation; `duty_sel` is ignored), the low phase lasts C input-clock cycles and the base high count is C, where C is the effective count.
- R2: With `fast_sel`=1 and `duty_sel`=0, the base high count is C and the low phase lasts 2×C cycles.
- R3: With `fast_sel`=1 and `duty_sel`=1, the base high count is 9×C and the low phase lasts 16×C cycles.
- R4: The effective count C is `cnt_cfg`, raised to 4 if it is smaller. In the `fast_sel`=1/`duty_sel`=1 mode the floor is 1 instead.
- R5: The high count starts only once the synchronized line (two flops) reads high. The released interval between two low phases is therefore stretch + 2 + high target cycles, where stretch is the number of cycles a slave keeps SCL low after release.
- R6: The high target is the base high count minus `rise_cfg`, or 1 if `rise_cfg` is at least the base high count.
- R7: Timing inputs are captured on every cycle while `enable` is 0. Changes while `enable` is 1 have no effect until the block has been disabled and enabled again.
- R8: From the first clock edge at which `enable` is sampled 0, SCL is released and neither strobe is issued.
- R9: `lo_strobe` is high only in the first cycle of each low phase. `hi_strobe` is high exactly once per high phase, in its first counted cycle. The two strobes are never high together.
- R10: `rise_calc` uses the frequency code clamped to 2..42. It equals code+1 when `fast_sel`=0 and floor(code×300/1000)+1 when `fast_sel`=1; a code of 8 gives 9 and 3.
- R11: While in reset and right after it, SCL is released and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (peripheral) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; timing inputs are captured while it is 0 |
| freq_mhz | input | 6 | Input clock frequency code in MHz, for the rise-time helper |
| cnt_cfg | input | 12 | Clock-control count |
| fast_sel | input | 1 | 0 standard, 1 fast |
| duty_sel | input | 1 | In fast operation: 0 for a 1:2 split, 1 for a 9:16 split |
| rise_cfg | input | 6 | Rise-time compensation credited against the high count |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| hi_strobe | output | 1 | First counted cycle of a high phase |
| lo_strobe | output | 1 | First cycle of a low phase |
| rise_calc | output | 6 | Rise-time value derived from `freq_mhz` and `fast_sel` |

## Verification
The rise-time helper is combinational, so the bench checks `rise_calc` one nanosecond after it changes the frequency code. The phase results are measured as run lengths of `scl_drive_low`, sampled at falling clock edges, and only from the second complete period after enabling. In that period the low run must equal the low length exactly, and the released run must equal stretch plus two synchronizer cycles plus the high target. Strobes are counted inside those runs. Quiet behaviour after disabling is checked from the first rising edge after `enable` drops, and a configuration change made while running is checked on the next measured period and again after re-enabling.

// File: rtl/scl_tim_pkg.sv
package scl_tim_pkg;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    RATIO_EVEN = 2'd0,
    RATIO_1_2  = 2'd1,
    RATIO_9_16 = 2'd2
  } ratio_e;

  function automatic ratio_e ratio_of(input logic fast, input logic duty);
    if (!fast)     return RATIO_EVEN;
    else if (duty) return RATIO_9_16;
    else           return RATIO_1_2;
  endfunction

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] sync_q;
      logic [STAGES-1:0] sync_d;
      always_comb begin
        sync_d = {sync_q[STAGES-2+((STAGES>1)?0:1):0], d};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
      end
      assign q = sync_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/scl_param_calc.sv
module scl_param_calc
  import scl_tim_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int FREQ_W   = 6,
  parameter int RISE_W   = 6,
  parameter int LEN_W    = 17,
  parameter int MIN_STD  = 4,
  parameter int MIN_FD   = 1,
  parameter int FREQ_MIN = 2,
  parameter int FREQ_MAX = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_cfg,
  input  logic              fast_sel,
  input  logic              duty_sel,
  input  logic [FREQ_W-1:0] freq_mhz,
  input  logic [RISE_W-1:0] rise_cfg,
  output logic [LEN_W-1:0]  hi_tgt,
  output logic [LEN_W-1:0]  lo_len,
  output logic [RISE_W-1:0] rise_calc
);
  localparam int PROD_W = FREQ_W + 9;

  ratio_e             ratio;
  logic [CNT_W-1:0]   min_cnt;
  logic [CNT_W-1:0]   eff_cnt;
  logic [LEN_W-1:0]   eff_ext;
  logic [LEN_W-1:0]   hi_base;
  logic [LEN_W-1:0]   rise_ext;
  logic [FREQ_W-1:0]  freq_cl;
  logic [PROD_W-1:0]  prod;
  logic [PROD_W-1:0]  quot;

  // Count floor and ratio expansion
  always_comb begin
    ratio   = ratio_of(fast_sel, duty_sel);
    min_cnt = (ratio == RATIO_9_16) ? CNT_W'(MIN_FD) : CNT_W'(MIN_STD);
    eff_cnt = (cnt_cfg < min_cnt) ? min_cnt : cnt_cfg;
    eff_ext = LEN_W'(eff_cnt);
    case (ratio)
      RATIO_1_2: begin
        hi_base = eff_ext;
        lo_len  = eff_ext << 1;
      end
      RATIO_9_16: begin
        hi_base = (eff_ext << 3) + eff_ext;
        lo_len  = eff_ext << 4;
      end
      default: begin
        hi_base = eff_ext;
        lo_len  = eff_ext;
      end
    endcase
    rise_ext = LEN_W'(rise_cfg);
    hi_tgt   = (hi_base > rise_ext) ? (hi_base - rise_ext) : LEN_W'(1);
  end

  // Rise-time helper from the frequency code
  always_comb begin
    if (freq_mhz < FREQ_W'(FREQ_MIN))      freq_cl = FREQ_W'(FREQ_MIN);
    else if (freq_mhz > FREQ_W'(FREQ_MAX)) freq_cl = FREQ_W'(FREQ_MAX);
    else                                   freq_cl = freq_mhz;
    prod = PROD_W'(freq_cl) * PROD_W'(300);
    quot = prod / PROD_W'(1000);
    if (fast_sel) rise_calc = RISE_W'(quot) + RISE_W'(1);
    else          rise_calc = RISE_W'(freq_cl) + RISE_W'(1);
  end

  // R4: the count feeding the expansion never drops under its floor
  a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_cnt >= CNT_W'(MIN_FD)) && (fast_sel && duty_sel || eff_cnt >= CNT_W'(MIN_STD)));
  // R6: the high target is never zero
  a_r6_target_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    hi_tgt != '0);
  // R10: helper output stays inside the range of the clamped code
  a_r10_rise_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_calc >= RISE_W'(1)) && (rise_calc <= RISE_W'(FREQ_MAX + 1)));
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_tim_pkg::*;
#(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             scl_hi,
  input  logic [LEN_W-1:0] hi_tgt_in,
  input  logic [LEN_W-1:0] lo_len_in,
  output logic             scl_drive_low,
  output logic             hi_strobe,
  output logic             lo_strobe
);
  phase_e           state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [LEN_W-1:0] hi_tgt_q, lo_len_q;
  logic             cfg_load;

  assign cfg_load = !enable;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_inc = cnt_q + LEN_W'(1);
    case (state_q)
      PH_OFF: begin
        if (enable) begin
          state_d = PH_HIGH;
          cnt_d   = '0;
        end
      end
      PH_HIGH: begin
        if (!enable) begin
          state_d = PH_OFF;
          cnt_d   = '0;
        end else if (scl_hi) begin
          if (cnt_inc == hi_tgt_q) begin
            state_d = PH_LOW;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_inc;
          end
        end
      end
      PH_LOW: begin
        if (!enable) begin
          state_d = PH_OFF;
          cnt_d   = '0;
        end else if (cnt_inc == lo_len_q) begin
          state_d = PH_HIGH;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      default: begin
        state_d = PH_OFF;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_tgt_q <= LEN_W'(1);
      lo_len_q <= LEN_W'(1);
    end else if (cfg_load) begin
      hi_tgt_q <= hi_tgt_in;
      lo_len_q <= lo_len_in;
    end
  end

  assign scl_drive_low = (state_q == PH_LOW);
  assign lo_strobe     = (state_q == PH_LOW) && (cnt_q == '0);
  assign hi_strobe     = (state_q == PH_HIGH) && scl_hi && (cnt_q == '0);

  // R8: disabling silences the line and strobes from the next edge
  a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !hi_strobe && !lo_strobe));
  // R7: captured timing holds while enabled
  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ($stable(hi_tgt_q) && $stable(lo_len_q)));
  // R1: the low counter never passes the captured low length
  a_r1_low_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_LOW) |-> (cnt_q < lo_len_q));
  // R5: a line held low freezes the high count
  a_r5_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_HIGH && enable && !scl_hi) |=> (state_q == PH_HIGH && cnt_q == $past(cnt_q)));
  // R9: strobes are exclusive and a low strobe marks the start of a pull-down
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_strobe, lo_strobe}));
  a_r9_lo_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    lo_strobe |-> $rose(scl_drive_low));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int CNT_W       = 12,
  parameter int FREQ_W      = 6,
  parameter int RISE_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_STD     = 4,
  parameter int MIN_FD      = 1,
  parameter int FREQ_MIN    = 2,
  parameter int FREQ_MAX    = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [FREQ_W-1:0] freq_mhz,
  input  logic [CNT_W-1:0]  cnt_cfg,
  input  logic              fast_sel,
  input  logic              duty_sel,
  input  logic [RISE_W-1:0] rise_cfg,
  input  logic              scl_in,
  output logic              scl_drive_low,
  output logic              hi_strobe,
  output logic              lo_strobe,
  output logic [RISE_W-1:0] rise_calc
);
  localparam int LEN_W = CNT_W + 5;

  logic [LEN_W-1:0] hi_tgt;
  logic [LEN_W-1:0] lo_len;
  logic             scl_hi;

  scl_param_calc #(
    .CNT_W(CNT_W), .FREQ_W(FREQ_W), .RISE_W(RISE_W), .LEN_W(LEN_W),
    .MIN_STD(MIN_STD), .MIN_FD(MIN_FD), .FREQ_MIN(FREQ_MIN), .FREQ_MAX(FREQ_MAX)
  ) u_calc (
    .clk(clk), .rst_n(rst_n),
    .cnt_cfg(cnt_cfg), .fast_sel(fast_sel), .duty_sel(duty_sel),
    .freq_mhz(freq_mhz), .rise_cfg(rise_cfg),
    .hi_tgt(hi_tgt), .lo_len(lo_len), .rise_calc(rise_calc)
  );

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_hi)
  );

  scl_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_hi(scl_hi),
    .hi_tgt_in(hi_tgt), .lo_len_in(lo_len),
    .scl_drive_low(scl_drive_low), .hi_strobe(hi_strobe), .lo_strobe(lo_strobe)
  );
endmodule

// File: tb/tb_scl_timing_gen.sv
`timescale 1ns/1ps
module tb_scl_timing_gen;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [5:0]  freq_mhz;
  logic [11:0] cnt_cfg;
  logic        fast_sel, duty_sel;
  logic [5:0]  rise_cfg;
  logic        scl_in;
  logic        scl_drive_low, hi_strobe, lo_strobe;
  logic [5:0]  rise_calc;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int stretch_amt = 0;
  int st_cnt = 0;

  always #2.5 clk = ~clk;

  // Slave model: holds SCL low for stretch_amt cycles after release
  always @(posedge clk) begin
    if (scl_drive_low) st_cnt <= stretch_amt;
    else if (st_cnt != 0) st_cnt <= st_cnt - 1;
  end
  assign scl_in = !scl_drive_low && (st_cnt == 0);

  scl_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .freq_mhz(freq_mhz),
    .cnt_cfg(cnt_cfg), .fast_sel(fast_sel), .duty_sel(duty_sel),
    .rise_cfg(rise_cfg), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .hi_strobe(hi_strobe), .lo_strobe(lo_strobe), .rise_calc(rise_calc)
  );

  function automatic int exp_c(int c, bit f, bit d);
    int mn = (f && d) ? 1 : 4;
    return (c < mn) ? mn : c;
  endfunction
  function automatic int exp_lo(int c, bit f, bit d);
    int e = exp_c(c, f, d);
    if (!f) return e;
    return d ? 16 * e : 2 * e;
  endfunction
  function automatic int exp_hi(int c, bit f, bit d, int r);
    int e = exp_c(c, f, d);
    int b = (f && d) ? 9 * e : e;
    return (b > r) ? b - r : 1;
  endfunction
  function automatic int exp_rise(int fr, bit f);
    int fc = (fr < 2) ? 2 : ((fr > 42) ? 42 : fr);
    return f ? (fc * 300) / 1000 + 1 : fc + 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(int c, bit f, bit d, int r);
    @(negedge clk);
    enable = 1'b0;
    cnt_cfg = 12'(c); fast_sel = f; duty_sel = d; rise_cfg = 6'(r);
    @(negedge clk);
    @(negedge clk);
    enable = 1'b1;
  endtask

  // Measure one complete low run and the released run after it
  task automatic measure(output int lo_w, output int hi_w, output int lo_st,
                         output int hi_st, output int lo_first);
    int g;
    lo_w = 0; hi_w = 0; lo_st = 0; hi_st = 0; lo_first = 0;
    g = 0;
    while (scl_drive_low !== 1'b0 && g < 70000) begin @(negedge clk); g++; end
    while (scl_drive_low !== 1'b1 && g < 140000) begin @(negedge clk); g++; end
    while (scl_drive_low === 1'b1 && lo_w < 70000) begin
      if (lo_strobe) lo_st++;
      if (lo_w == 0) lo_first = int'(lo_strobe);
      if (hi_strobe) hi_st += 100;
      lo_w++;
      @(negedge clk);
    end
    while (scl_drive_low === 1'b0 && hi_w < 70000) begin
      if (hi_strobe) hi_st++;
      if (lo_strobe) lo_st += 100;
      hi_w++;
      @(negedge clk);
    end
  endtask

  task automatic run_mode(string tag, int c, bit f, bit d, int r, int s);
    int lw, hw, ls, hs, lf;
    stretch_amt = s;
    configure(c, f, d, r);
    measure(lw, hw, ls, hs, lf);
    measure(lw, hw, ls, hs, lf);
    chk({tag, " low length"}, lw, exp_lo(c, f, d));
    chk({tag, " released length"}, hw, s + SYNC + exp_hi(c, f, d, r));
    chk("R9 low strobe count", ls, 1);
    chk("R9 high strobe count", hs, 1);
    chk("R9 low strobe first cycle", lf, 1);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lw, hw, ls, hs, lf, bad, seed_dummy;
    rst_n = 1'b0; enable = 1'b0; freq_mhz = 6'd8; cnt_cfg = 12'd10;
    fast_sel = 1'b0; duty_sel = 1'b0; rise_cfg = 6'd0;
    repeat (5) @(negedge clk);
    chk("R11 drive in reset", int'(scl_drive_low), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 drive after reset", int'(scl_drive_low), 0);
    chk("R11 strobes after reset", int'(hi_strobe) + int'(lo_strobe), 0);

    // R10 helper
    for (int m = 0; m < 2; m++) begin
      for (int fr = 0; fr < 64; fr++) begin
        fast_sel = m[0]; freq_mhz = 6'(fr);
        #1;
        chk("R10 rise helper", int'(rise_calc), exp_rise(fr, m[0]));
      end
    end
    freq_mhz = 6'd8; fast_sel = 1'b0; #1;
    chk("R10 code 8 standard", int'(rise_calc), 9);
    fast_sel = 1'b1; #1;
    chk("R10 code 8 fast", int'(rise_calc), 3);

    // Modes, floors, credit, stretching
    run_mode("R1", 10, 0, 0, 0, 0);
    run_mode("R1 duty ignored", 7, 0, 1, 0, 0);
    run_mode("R2", 10, 1, 0, 0, 0);
    run_mode("R3", 3, 1, 1, 0, 0);
    run_mode("R4 std floor", 2, 0, 0, 0, 0);
    run_mode("R4 fast floor", 0, 1, 0, 0, 0);
    run_mode("R4 9:16 floor", 0, 1, 1, 0, 0);
    run_mode("R6 credit", 10, 0, 0, 3, 0);
    run_mode("R6 credit floor", 5, 0, 0, 20, 0);
    run_mode("R6 9:16 credit", 1, 1, 1, 3, 0);
    run_mode("R5 stretch", 6, 1, 0, 0, 7);
    run_mode("R5 stretch 9:16", 2, 1, 1, 2, 3);
    run_mode("R1 large count", 4095, 0, 0, 0, 0);

    // R7 change while enabled is ignored
    stretch_amt = 0;
    configure(6, 0, 0, 0);
    measure(lw, hw, ls, hs, lf);
    @(negedge clk);
    cnt_cfg = 12'd20; fast_sel = 1'b1; duty_sel = 1'b1;
    measure(lw, hw, ls, hs, lf);
    measure(lw, hw, ls, hs, lf);
    chk("R7 low while enabled", lw, 6);
    chk("R7 released while enabled", hw, SYNC + 6);
    configure(20, 0, 0, 0);
    measure(lw, hw, ls, hs, lf);
    measure(lw, hw, ls, hs, lf);
    chk("R7 low after re-enable", lw, 20);

    // R8 disable
    measure(lw, hw, ls, hs, lf);
    @(negedge clk);
    while (!scl_drive_low) @(negedge clk);
    enable = 1'b0;
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (scl_drive_low || hi_strobe || lo_strobe) bad++;
    end
    chk("R8 quiet while disabled", bad, 0);

    // Random mix with fixed seed
    seed_dummy = int'($urandom(32'd20161223));
    for (int it = 0; it < 16; it++) begin
      int c = int'($urandom_range(0, 40));
      bit f = 1'($urandom_range(0, 1));
      bit d = 1'($urandom_range(0, 1));
      int r = int'($urandom_range(0, 20));
      int s = int'($urandom_range(0, 5));
      run_mode(f ? (d ? "R3 random" : "R2 random") : "R1 random", c, f, d, r, s);
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule